// File: doc/BRIEF.md
# Run-Time Programmable Logic Array

This block is a small sum-of-products logic array whose function is set at run time. It has `NUM_IN` inputs, `NUM_TERM` product terms and `NUM_OUT` outputs. The first plane is programmable: each product term ANDs together any mix of true and complemented inputs. The second plane is also programmable: it ORs any set of product terms onto each output. A single product term may feed any number of outputs, so one term can serve several functions.

The complete setting of both planes is called the personality. It is held in registers and loaded over a one-bit serial port. Bits are shifted in one per clock, and a separate strobe copies the shifted word into the active personality in a single step. The path from `inVec` to `outVec` is purely combinational. It depends only on the inputs and on the personality that was last committed.

Top module: `prog_logic_array`

## Requirements
- R1: After reset every AND code is 00 and every OR bit is 0, so `outVec` is all zeros for every input value until a personality is committed.
- R2: Each input position of each product term has a two-bit code at word bits 2*(t*NUM_IN+i) and 2*(t*NUM_IN+i)+1. Code 00 means the input is ignored. Code 01 (low bit set) uses the true input. Code 10 (high bit set) uses the complemented input.
- R3: Code 11 at any input position forces that product term to 0 for every input value.
- R4: A product term whose codes are all 00 evaluates to constant 1.
- R5: OR bit at word index 2*NUM_IN*NUM_TERM + t*NUM_OUT + o connects term t to output o. Each output is the OR of its connected terms, and an output with no connected term is constant 0.
- R6: One product term connected to several outputs drives all of them at the same time.
- R7: In each clock with `cfgValid` high and `cfgDone` low, `cfgBit` is shifted in. After a full word of `2*NUM_IN*NUM_TERM + NUM_TERM*NUM_OUT` shifts, the first bit shifted occupies word bit 0 and the last occupies the top bit. The AND plane is therefore sent first, lowest index first, followed by the OR plane.
- R8: A clock with `cfgDone` high copies the whole shifted word into the personality at once. The outputs follow the new personality from that edge onward.
- R9: Shifting without `cfgDone` leaves the committed personality, and so the outputs, unchanged.
- R10: When `cfgDone` and `cfgValid` are both high in the same clock, the bit is not shifted. Committing again later therefore yields the same personality.
- R11: `outVec` follows a change of `inVec` within the same clock cycle, without waiting for a clock edge.
- R12: With terms AB, B'C, AC', B'C' and A (A=`inVec[0]`, B=`inVec[1]`, C=`inVec[2]`), wired as F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A on `outVec[0..3]`, all 8 input values give the correct outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration logic |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Shift `cfgBit` into the load register this clock |
| cfgBit | input | 1 | Serial personality data |
| cfgDone | input | 1 | Commit the load register to the active personality |
| inVec | input | NUM_IN | Logic inputs |
| outVec | output | NUM_OUT | Logic outputs, combinational from `inVec` |

## Verification
The assertions assume that `cfgValid`, `cfgBit` and `cfgDone` are sampled only at rising edges and are free of X once reset is released. They also assume that the reset is held for at least one edge, so that their look-back never reaches an unreset register. The stimulus changes the configuration inputs only at falling edges and holds each one steady across the following rising edge. `inVec` is changed mid-cycle only in the combinational-path test, because the planes have no clocked state on that path.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Strobes from the configuration control to the personality store
  typedef struct packed {
    logic shiftEn;   // move one serial bit into the load register
    logic commit;    // copy the load register into the active personality
  } cfgStrobe_t;

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic       cfgValid,
  input  logic       cfgDone,
  output cfgStrobe_t strobe
);

  // Commit wins over shift: a bit offered in a commit cycle is dropped (R10)
  always_comb begin
    strobe.commit  = cfgDone;
    strobe.shiftEn = cfgValid & ~cfgDone;
  end

endmodule

// File: rtl/pla_store.sv
module pla_store
  import pla_pkg::*;
#(
  parameter int NUM_IN   = 3,
  parameter int NUM_TERM = 5,
  parameter int NUM_OUT  = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cfgStrobe_t                       strobe,
  input  logic                             cfgBit,
  output logic [2*NUM_IN*NUM_TERM-1:0]     andPlane,
  output logic [NUM_TERM*NUM_OUT-1:0]      orPlane
);

  localparam int AND_BITS = 2 * NUM_IN * NUM_TERM;
  localparam int OR_BITS  = NUM_TERM * NUM_OUT;
  localparam int CFG_BITS = AND_BITS + OR_BITS;

  logic [CFG_BITS-1:0] shiftReg;
  logic [CFG_BITS-1:0] persona;

  // Load register: new bit enters at the top, so the first bit sent ends at bit 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {cfgBit, shiftReg[CFG_BITS-1:1]};
    end
  end

  // Active personality: whole word replaced in one edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      persona <= '0;
    end else if (strobe.commit) begin
      persona <= shiftReg;
    end
  end

  assign andPlane = persona[AND_BITS-1:0];
  assign orPlane  = persona[CFG_BITS-1:AND_BITS];

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> shiftReg[CFG_BITS-1] == $past(cfgBit)); // R7

  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> {orPlane, andPlane} == $past(shiftReg)); // R8

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable({orPlane, andPlane})); // R9

  AST_NO_SHIFT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> $stable(shiftReg)); // R10

endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int NUM_IN   = 3,
  parameter int NUM_TERM = 5,
  parameter int NUM_OUT  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_IN-1:0]            inVec,
  input  logic [2*NUM_IN*NUM_TERM-1:0] andPlane,
  input  logic [NUM_TERM*NUM_OUT-1:0]  orPlane,
  output logic [NUM_OUT-1:0]           outVec
);

  localparam int CODE_W = 2 * NUM_IN;

  logic [NUM_TERM-1:0][NUM_IN-1:0]  litOk;
  logic [NUM_TERM-1:0]              termVal;
  logic [NUM_OUT-1:0][NUM_TERM-1:0] colMask;

  // AND plane: a literal blocks the term only when its enabled polarity is false
  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
      logic useTrue;
      logic useCompl;
      assign useTrue     = andPlane[2*(t*NUM_IN+i)];
      assign useCompl    = andPlane[2*(t*NUM_IN+i)+1];
      assign litOk[t][i] = ~(useTrue & ~inVec[i]) & ~(useCompl & inVec[i]);

      AST_DUAL_CODE_LOW: assert property (@(posedge clk) disable iff (!rstN)
        (useTrue && useCompl) |-> !termVal[t]); // R3
    end
    assign termVal[t] = &litOk[t];

    AST_EMPTY_TERM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (andPlane[t*CODE_W +: CODE_W] == '0) |-> termVal[t]); // R4
  end

  // OR plane: gather each output's column of connection bits
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    for (genvar t = 0; t < NUM_TERM; t++) begin : g_conn
      assign colMask[o][t] = orPlane[t*NUM_OUT+o];
    end
    assign outVec[o] = |(colMask[o] & termVal);

    AST_UNCONNECTED_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (colMask[o] == '0) |-> !outVec[o]); // R5
  end

endmodule

// File: rtl/prog_logic_array.sv
module prog_logic_array
  import pla_pkg::*;
#(
  parameter int NUM_IN   = 3,
  parameter int NUM_TERM = 5,
  parameter int NUM_OUT  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic               cfgBit,
  input  logic               cfgDone,
  input  logic [NUM_IN-1:0]  inVec,
  output logic [NUM_OUT-1:0] outVec
);

  localparam int AND_BITS = 2 * NUM_IN * NUM_TERM;
  localparam int OR_BITS  = NUM_TERM * NUM_OUT;

  cfgStrobe_t          strobe;
  logic [AND_BITS-1:0] andPlane;
  logic [OR_BITS-1:0]  orPlane;

  pla_ctrl u_ctrl (
    .cfgValid (cfgValid),
    .cfgDone  (cfgDone),
    .strobe   (strobe)
  );

  pla_store #(
    .NUM_IN   (NUM_IN),
    .NUM_TERM (NUM_TERM),
    .NUM_OUT  (NUM_OUT)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgBit   (cfgBit),
    .andPlane (andPlane),
    .orPlane  (orPlane)
  );

  pla_eval #(
    .NUM_IN   (NUM_IN),
    .NUM_TERM (NUM_TERM),
    .NUM_OUT  (NUM_OUT)
  ) u_eval (
    .clk      (clk),
    .rstN     (rstN),
    .inVec    (inVec),
    .andPlane (andPlane),
    .orPlane  (orPlane),
    .outVec   (outVec)
  );

endmodule

// File: tb/prog_logic_array_test.sv
`timescale 1ns/1ps
module prog_logic_array_test;

  localparam int NI = 3;
  localparam int NT = 5;
  localparam int NO = 4;
  localparam int AND_BITS = 2 * NI * NT;
  localparam int TOTAL = AND_BITS + NT * NO;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0;
  logic cfgBit = 1'b0;
  logic cfgDone = 1'b0;
  logic [NI-1:0] inVec = '0;
  logic [NO-1:0] outVec;

  int nChecks = 0;
  int nFail = 0;
  bit running = 1'b0;

  logic [TOTAL-1:0] mPers = '0;
  bit shiftQ[$];
  logic [TOTAL-1:0] word;

  always #2 clk = ~clk;

  prog_logic_array #(.NUM_IN(NI), .NUM_TERM(NT), .NUM_OUT(NO)) uut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .inVec(inVec), .outVec(outVec)
  );

  task automatic checkVal(string tag, logic [NO-1:0] got, logic [NO-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: inVec=%b got %b expected %b", tag, inVec, got, exp);
    end
  endtask

  // Word image of the bits queued so far: earlier bits sit lower, unfilled low bits stay 0
  function automatic logic [TOTAL-1:0] assemble();
    logic [TOTAL-1:0] w = '0;
    int s = shiftQ.size();
    for (int j = 0; j < s; j++) w[TOTAL - s + j] = shiftQ[j];
    return w;
  endfunction

  function automatic logic [NO-1:0] modelOut(logic [NI-1:0] x);
    logic [NO-1:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      bit tv = 1;
      for (int i = 0; i < NI; i++) begin
        if (mPers[2*(t*NI+i)] && !x[i]) tv = 0;
        if (mPers[2*(t*NI+i)+1] && x[i]) tv = 0;
      end
      for (int o = 0; o < NO; o++)
        if (tv && mPers[AND_BITS + t*NO + o]) r[o] = 1'b1;
    end
    return r;
  endfunction

  // Reference model updated at each edge, compared shortly after it (R8)
  always @(posedge clk) begin
    if (!rstN) begin
      mPers = '0;
      shiftQ.delete();
    end else if (cfgDone) begin
      mPers = assemble();
    end else if (cfgValid) begin
      shiftQ.push_back(cfgBit);
      if (shiftQ.size() > TOTAL) void'(shiftQ.pop_front());
    end
    #1;
    if (running) checkVal("R8 per-clock", outVec, modelOut(inVec));
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  task automatic setCode(int t, int i, logic [1:0] code);
    word[2*(t*NI+i)]   = code[0];
    word[2*(t*NI+i)+1] = code[1];
  endtask

  task automatic setOr(int t, int o);
    word[AND_BITS + t*NO + o] = 1'b1;
  endtask

  task automatic shiftWord(logic [TOTAL-1:0] w);
    for (int k = 0; k < TOTAL; k++) begin
      @(negedge clk);
      cfgValid = 1'b1;
      cfgBit = w[k];
    end
    @(negedge clk);
    cfgValid = 1'b0;
    cfgBit = 1'b0;
  endtask

  task automatic commitCfg();
    @(negedge clk);
    cfgDone = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
  endtask

  initial begin
    logic a, b, c;
    logic [NO-1:0] exp;

    // R1: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      inVec = v[NI-1:0];
      #1 checkVal("R1 reset outputs zero", outVec, 4'b0000);
    end

    // Example personality: t0=AB t1=B'C t2=AC' t3=B'C' t4=A
    word = '0;
    setCode(0, 0, 2'b01); setCode(0, 1, 2'b01);
    setCode(1, 1, 2'b10); setCode(1, 2, 2'b01);
    setCode(2, 0, 2'b01); setCode(2, 2, 2'b10);
    setCode(3, 1, 2'b10); setCode(3, 2, 2'b10);
    setCode(4, 0, 2'b01);
    setOr(3, 0); setOr(4, 0);
    setOr(2, 1); setOr(0, 1);
    setOr(3, 2); setOr(0, 2);
    setOr(1, 3); setOr(4, 3);
    shiftWord(word);

    // R9: shifted but uncommitted word has no effect
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      inVec = v[NI-1:0];
      #1 checkVal("R9 uncommitted word ignored", outVec, 4'b0000);
    end

    commitCfg();
    // R12 with R2 and R7 (bit order): compare with the functions themselves
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      inVec = v[NI-1:0];
      a = inVec[0]; b = inVec[1]; c = inVec[2];
      exp[0] = a | (~b & ~c);
      exp[1] = (a & ~c) | (a & b);
      exp[2] = (~b & ~c) | (a & b);
      exp[3] = (~b & c) | a;
      #1 checkVal("R12 example functions", outVec, exp);
    end

    // R6: AB shared by F1 and F2
    @(negedge clk);
    inVec = 3'b111;
    #1 checkVal("R6 shared term", outVec & 4'b0110, 4'b0110);

    // R11: combinational path reacts mid-cycle
    @(posedge clk);
    #2 inVec = 3'b000;
    #0.5 checkVal("R11 comb 000", outVec, 4'b0101);
    inVec = 3'b100;
    #0.5 checkVal("R11 comb 100", outVec, 4'b1000);

    // R2, R7, R5: single term A&~B on output 0 only
    word = '0;
    setCode(0, 0, 2'b01); setCode(0, 1, 2'b10);
    setOr(0, 0);
    shiftWord(word);
    commitCfg();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      inVec = v[NI-1:0];
      exp = '0;
      exp[0] = inVec[0] & ~inVec[1];
      #1 checkVal("R2 R7 literal codes and order", outVec, exp);
    end

    // R4, R3, R5: empty term to outputs 0 and 3; dual-code term to output 1; output 2 open
    word = '0;
    setOr(0, 0); setOr(0, 3);
    setCode(1, 1, 2'b11); setOr(1, 1);
    for (int t = 2; t < NT; t++) setCode(t, 0, 2'b11);
    shiftWord(word);
    // R10: commit with a stray bit offered in the same cycle
    @(negedge clk);
    cfgDone = 1'b1;
    cfgValid = 1'b1;
    cfgBit = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
    cfgValid = 1'b0;
    cfgBit = 1'b0;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      inVec = v[NI-1:0];
      #1 checkVal("R4 R3 R5 constants", outVec, 4'b1001);
    end
    commitCfg();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      inVec = v[NI-1:0];
      #1 checkVal("R10 stray bit not shifted", outVec, 4'b1001);
    end

    running = 1'b0;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule